// File: doc/BRIEF.md
# 1-Wire Slave Bit Interface

This block is the bit-level front end of a slave on a single-wire, open-drain bus. The bus rests high, and the block can only pull the wire low or let it go. It never drives a high level. The block watches a sample of the wire and measures how long each low period lasts. A long low is a reset from the master, and the block answers it with a presence pulse. Shorter lows are time slots: each one is opened by the master's falling edge, and in it one bit moves.

When no transmit byte is pending, each slot is a write slot. The block samples the wire a fixed time after the falling edge and shifts that bit into a receive byte. When the higher layer has loaded a byte, the following slots are read slots. In each of them the block pulls the wire low for a '0' bit and leaves it alone for a '1' bit. All durations are counted in ticks of a 1 µs enable input. A speed input chooses between the standard and overdrive timing sets. The higher layer decodes commands, so it is told which received byte is the first one after each bus reset.

Top module: `onewire_slave_phy`

## Requirements
- R1: After the synchronous reset, pull_o, reset_o, rx_valid_o and tx_req_o are all 0.
- R2: At standard speed (fast_i=0), a low of at least 121 ticks gives a one-cycle reset_o pulse exactly 3 clock cycles after the wire is released. A low of 118 ticks or less is not a reset.
- R3: At overdrive speed (fast_i=1), the reset limit is 16 ticks. A low of 20 ticks is a reset and a low of 14 ticks is not.
- R4: After a reset, the block waits 30 ticks (standard) or 3 ticks (overdrive) and then asserts pull_o for 120 or 12 ticks, each within one tick. pull_o is 0 in the reset_o cycle.
- R5: In a write slot, the wire is sampled 30 ticks (standard) or 3 ticks (overdrive) after the falling edge is seen. High is 1 and low is 0. Bits fill the byte least significant first. After the eighth bit, rx_valid_o is high for one cycle with the byte on rx_data_o.
- R6: rx_first_o is 1 together with rx_valid_o for the first byte completed after a bus reset, and 0 for every later byte. It is never high without rx_valid_o.
- R7: After a tx_load_i pulse, the next eight slots send tx_data_i least significant bit first. For a 0 bit, pull_o is held from the falling edge until the sample point, and for a 1 bit pull_o stays low. rx_valid_o and tx_req_o are never high together.
- R8: After the eighth transmitted bit, tx_req_o is high for one cycle and the slots that follow are write slots again.
- R9: A bus reset discards a partly received byte and cancels a pending transmit byte, so the next byte is received from its first bit and no tx_req_o is produced.
- R10: Outside a presence pulse or a read slot with a 0 bit, pull_o is never asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle enable every 1 µs |
| fast_i | input | 1 | 1 selects overdrive timing, 0 standard |
| line_i | input | 1 | Raw sample of the bus wire |
| pull_o | output | 1 | 1 pulls the wire low, 0 releases it |
| reset_o | output | 1 | One-cycle pulse when a bus reset ends |
| rx_data_o | output | 8 | Received byte, valid with rx_valid_o |
| rx_valid_o | output | 1 | One-cycle strobe for a received byte |
| rx_first_o | output | 1 | Marks the first byte after a bus reset |
| tx_data_i | input | 8 | Byte to send in the coming read slots |
| tx_load_i | input | 1 | Loads tx_data_i and arms the read slots |
| tx_req_o | output | 1 | One-cycle pulse when the byte has been sent |

## Verification
The wire passes through a two-stage synchroniser, and the control state is registered after it. So reset_o is due exactly three clock cycles after the master releases a reset pulse, and the bench checks it on that cycle. Presence start, presence length and the sample point depend on where the 1 µs tick falls, so the bench measures them in clock cycles and accepts a one-tick window. Byte strobes and transmit requests come at the sample point of the eighth slot. The bench does not time them: a driver task queues each expected event, and a monitor compares events in order as they come out, so a missing, extra or wrong event is caught.

// File: rtl/ow_phy_pkg.sv
// Package of shared types for the single-wire slave bit interface.
// Holds the control state encoding and a helper that selects a timing value
// by speed mode. Assumes a caller that casts the result to its counter width.
package ow_phy_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,        // wire high, waiting for a falling edge
        ST_SLOT,        // inside a bit slot, counting to the sample point
        ST_WAIT_HIGH,   // slot bit done, waiting for the wire to return high
        ST_PRES_WAIT,   // reset seen, waiting before the presence pulse
        ST_PRES_PULL,   // driving the presence pulse
        ST_PRES_END     // presence released, waiting for the wire to rise
    } ow_state_e;

    function automatic int pick_timing(input logic fast, input int std_v, input int ovd_v);
        return fast ? ovd_v : std_v;
    endfunction

endpackage

// File: rtl/ow_line_sync.sv
// Brings the raw wire sample into the clock domain and finds its edges.
// Assumes the wire rests high, so every stage resets to 1. cur_o lags the
// wire by STAGES cycles, and fell_o/rose_o are single-cycle edge flags.
module ow_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic cur_o,
    output logic fell_o,
    output logic rose_o
);
    logic [STAGES:0] chain;

    // shift the wire sample through the synchroniser and one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-1:0], line_i};
    end

    assign cur_o  = chain[STAGES-1];
    assign fell_o = chain[STAGES] & ~chain[STAGES-1];
    assign rose_o = ~chain[STAGES] & chain[STAGES-1];
endmodule

// File: rtl/ow_low_timer.sv
// Counts microsecond ticks while the synchronised wire is low.
// The count clears on the first cycle the wire is seen high, so on that
// cycle the register still holds the length of the low that just ended.
// It saturates at all ones.
module ow_low_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             line_cur_i,
    output logic [CNT_W-1:0] low_cnt_o
);
    // measure the current low period in ticks
    always_ff @(posedge clk) begin
        if (!rst_n)                          low_cnt_o <= '0;
        else if (line_cur_i)                 low_cnt_o <= '0;
        else if (tick_i && low_cnt_o != '1)  low_cnt_o <= low_cnt_o + CNT_W'(1);
    end
endmodule

// File: rtl/ow_slot_ctrl.sv
// Slot and reset sequencer. It classifies each low period and tells a bus
// reset apart from a bit slot on the rising edge. It times the presence
// pulse, finds the sample point in each slot and drives the pull-low output
// for read slots. The timing inputs come already matched to the speed mode,
// and that mode is assumed to change only while the bus is idle.
module ow_slot_ctrl
    import ow_phy_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             cur_i,
    input  logic             fell_i,
    input  logic             rose_i,
    input  logic [CNT_W-1:0] low_cnt_i,
    input  logic [CNT_W-1:0] rst_min_i,
    input  logic [CNT_W-1:0] sample_i,
    input  logic [CNT_W-1:0] pd_wait_i,
    input  logic [CNT_W-1:0] pd_len_i,
    input  logic             tx_active_i,
    input  logic             tx_bit_i,
    output logic             pull_o,
    output logic             bus_reset_o,
    output logic             bit_stb_o,
    output logic             bit_val_o
);
    ow_state_e        state;
    logic [CNT_W-1:0] phase;
    logic             in_presence;
    logic             reset_hit;
    logic             phase_end;

    assign in_presence = (state == ST_PRES_PULL) || (state == ST_PRES_END);
    assign reset_hit   = rose_i && (low_cnt_i >= rst_min_i) && !in_presence;

    // phase end: this tick completes the interval timed in the current state
    always_comb begin
        unique case (state)
            ST_SLOT:      phase_end = tick_i && (phase == sample_i - CNT_W'(1));
            ST_PRES_WAIT: phase_end = tick_i && (phase == pd_wait_i - CNT_W'(1));
            ST_PRES_PULL: phase_end = tick_i && (phase == pd_len_i - CNT_W'(1));
            default:      phase_end = 1'b0;
        endcase
    end

    // sequence the slots, the reset detection and the presence pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            phase       <= '0;
            bus_reset_o <= 1'b0;
        end else begin
            bus_reset_o <= 1'b0;
            if (reset_hit) begin
                state       <= ST_PRES_WAIT;
                phase       <= '0;
                bus_reset_o <= 1'b1;
            end else begin
                unique case (state)
                    ST_IDLE: if (fell_i) begin
                        state <= ST_SLOT;
                        phase <= '0;
                    end
                    ST_SLOT:
                        if (phase_end)   state <= ST_WAIT_HIGH;
                        else if (tick_i) phase <= phase + CNT_W'(1);
                    ST_WAIT_HIGH: if (cur_i) state <= ST_IDLE;
                    ST_PRES_WAIT:
                        if (phase_end) begin
                            state <= ST_PRES_PULL;
                            phase <= '0;
                        end else if (tick_i) phase <= phase + CNT_W'(1);
                    ST_PRES_PULL:
                        if (phase_end)   state <= ST_PRES_END;
                        else if (tick_i) phase <= phase + CNT_W'(1);
                    ST_PRES_END: if (cur_i) state <= ST_IDLE;
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign bit_stb_o = (state == ST_SLOT) && phase_end;
    assign bit_val_o = cur_i;
    assign pull_o    = (state == ST_PRES_PULL) ||
                       ((state == ST_SLOT) && tx_active_i && !tx_bit_i);
endmodule

// File: rtl/ow_byte_shift.sv
// Byte assembly for both directions, least significant bit first.
// Each bit strobe moves one bit: out of the transmit register while a loaded
// byte is pending, otherwise into the receive register. A bus reset clears
// both partial bytes and arms the first-byte marker. Assumes tx loads arrive
// between slots.
module ow_byte_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              bit_stb_i,
    input  logic              bit_val_i,
    input  logic              tx_load_i,
    input  logic [DATA_W-1:0] tx_data_i,
    output logic              tx_active_o,
    output logic              tx_bit_o,
    output logic              tx_req_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic              rx_first_o
);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    logic [DATA_W-1:0] tx_sr;
    logic [DATA_W-1:0] rx_sr;
    logic [BIT_W-1:0]  tx_cnt;
    logic [BIT_W-1:0]  rx_cnt;
    logic              first_armed;

    // move one bit per strobe and flag finished bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr       <= '0;
            rx_sr       <= '0;
            tx_cnt      <= '0;
            rx_cnt      <= '0;
            tx_active_o <= 1'b0;
            tx_req_o    <= 1'b0;
            rx_data_o   <= '0;
            rx_valid_o  <= 1'b0;
            rx_first_o  <= 1'b0;
            first_armed <= 1'b0;
        end else begin
            tx_req_o   <= 1'b0;
            rx_valid_o <= 1'b0;
            rx_first_o <= 1'b0;
            if (clear_i) begin
                tx_cnt      <= '0;
                rx_cnt      <= '0;
                tx_active_o <= 1'b0;
                first_armed <= 1'b1;
            end else if (bit_stb_i) begin
                if (tx_active_o) begin
                    tx_sr  <= tx_sr >> 1;
                    tx_cnt <= tx_cnt + BIT_W'(1);
                    if (tx_cnt == LAST_BIT) begin
                        tx_active_o <= 1'b0;
                        tx_req_o    <= 1'b1;
                    end
                end else begin
                    rx_sr  <= {bit_val_i, rx_sr[DATA_W-1:1]};
                    rx_cnt <= rx_cnt + BIT_W'(1);
                    if (rx_cnt == LAST_BIT) begin
                        rx_data_o   <= {bit_val_i, rx_sr[DATA_W-1:1]};
                        rx_valid_o  <= 1'b1;
                        rx_first_o  <= first_armed;
                        first_armed <= 1'b0;
                    end
                end
            end else if (tx_load_i) begin
                tx_sr       <= tx_data_i;
                tx_cnt      <= '0;
                tx_active_o <= 1'b1;
            end
        end
    end

    assign tx_bit_o = tx_sr[0];
endmodule

// File: rtl/onewire_slave_phy.sv
// Top of the single-wire slave bit interface. It synchronises the wire,
// measures low periods, runs the slot and presence sequencer and assembles
// bytes. It also picks the standard or overdrive timing set from fast_i.
// Timing parameters are in 1 us ticks, and the output can only pull low.
module onewire_slave_phy
    import ow_phy_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int STD_RST_MIN = 121,
    parameter int OVD_RST_MIN = 16,
    parameter int STD_SAMPLE  = 30,
    parameter int OVD_SAMPLE  = 3,
    parameter int STD_PD_WAIT = 30,
    parameter int OVD_PD_WAIT = 3,
    parameter int STD_PD_LEN  = 120,
    parameter int OVD_PD_LEN  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              fast_i,
    input  logic              line_i,
    output logic              pull_o,
    output logic              reset_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic              rx_first_o,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_load_i,
    output logic              tx_req_o
);
    localparam int CNT_W = $clog2(STD_RST_MIN + STD_SAMPLE + STD_PD_WAIT + STD_PD_LEN + 2);

    logic             cur, fell, rose;
    logic [CNT_W-1:0] low_cnt;
    logic [CNT_W-1:0] rst_min, sample, pd_wait, pd_len;
    logic             tx_active, tx_bit, bit_stb, bit_val;

    assign rst_min = CNT_W'(pick_timing(fast_i, STD_RST_MIN, OVD_RST_MIN));
    assign sample  = CNT_W'(pick_timing(fast_i, STD_SAMPLE,  OVD_SAMPLE));
    assign pd_wait = CNT_W'(pick_timing(fast_i, STD_PD_WAIT, OVD_PD_WAIT));
    assign pd_len  = CNT_W'(pick_timing(fast_i, STD_PD_LEN,  OVD_PD_LEN));

    ow_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .line_i(line_i),
        .cur_o(cur), .fell_o(fell), .rose_o(rose)
    );

    ow_low_timer #(.CNT_W(CNT_W)) u_low (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .line_cur_i(cur), .low_cnt_o(low_cnt)
    );

    ow_slot_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .cur_i(cur), .fell_i(fell), .rose_i(rose), .low_cnt_i(low_cnt),
        .rst_min_i(rst_min), .sample_i(sample), .pd_wait_i(pd_wait), .pd_len_i(pd_len),
        .tx_active_i(tx_active), .tx_bit_i(tx_bit),
        .pull_o(pull_o), .bus_reset_o(reset_o),
        .bit_stb_o(bit_stb), .bit_val_o(bit_val)
    );

    ow_byte_shift #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clear_i(reset_o),
        .bit_stb_i(bit_stb), .bit_val_i(bit_val),
        .tx_load_i(tx_load_i), .tx_data_i(tx_data_i),
        .tx_active_o(tx_active), .tx_bit_o(tx_bit), .tx_req_o(tx_req_o),
        .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o), .rx_first_o(rx_first_o)
    );
endmodule

// File: rtl/ow_phy_checker.sv
// Protocol checker for the single-wire slave bit interface, bound to the top.
// It looks only at top-level ports and assumes the synchronous active-low reset.
module ow_phy_checker (
    input logic clk,
    input logic rst_n,
    input logic pull_o,
    input logic reset_o,
    input logic rx_valid_o,
    input logic rx_first_o,
    input logic tx_req_o
);
    AST_RESET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reset_o |=> !reset_o); // R2
    AST_NO_PULL_ON_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        reset_o |-> !pull_o); // R4
    AST_RX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o); // R5
    AST_FIRST_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_first_o |-> rx_valid_o); // R6
    AST_RX_TX_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid_o && tx_req_o)); // R7
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req_o |=> !tx_req_o); // R8
endmodule

bind onewire_slave_phy ow_phy_checker u_chk (
    .clk(clk), .rst_n(rst_n), .pull_o(pull_o), .reset_o(reset_o),
    .rx_valid_o(rx_valid_o), .rx_first_o(rx_first_o), .tx_req_o(tx_req_o)
);

// File: tb/onewire_slave_phy_test.sv
// Scoreboard bench: master tasks drive the wire and queue expected events,
// a monitor pops and compares them as the design strobes its outputs.
module onewire_slave_phy_test;
    localparam int TICK_DIV = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       fast = 1'b0;
    logic       m_low = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_load = 1'b0;
    wire        line;
    logic       pull, reset_p, rx_valid, rx_first, tx_req;
    logic [7:0] rx_data;

    int checks = 0;
    int errors = 0;
    int stray  = 0;
    bit pull_allowed = 1'b0;
    bit done = 1'b0;
    int div = 0;

    typedef struct {
        int         kind;   // 0 reset, 1 received byte, 2 transmit request
        logic [7:0] data;
        logic       first;
        string      req;
    } ev_t;
    ev_t exp_q[$];

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        div  <= (div == TICK_DIV - 1) ? 0 : div + 1;
        tick <= (div == TICK_DIV - 1);
    end

    assign line = ~(m_low | pull);

    onewire_slave_phy uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .fast_i(fast), .line_i(line),
        .pull_o(pull), .reset_o(reset_p), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
        .rx_first_o(rx_first), .tx_data_i(tx_data), .tx_load_i(tx_load), .tx_req_o(tx_req)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic wait_us(input int n);
        repeat (n * TICK_DIV) @(negedge clk);
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compare every output event with the queue head
    always @(negedge clk) begin
        if (rst_n && (reset_p || rx_valid || tx_req)) begin
            int kind;
            kind = reset_p ? 0 : (rx_valid ? 1 : 2);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9", "unexpected event kind", kind, -1);
            end else begin
                ev_t e;
                e = exp_q.pop_front();
                chk(kind == e.kind, e.req, "event kind", kind, e.kind);
                if (kind == 1 && e.kind == 1) begin
                    chk(rx_data == e.data, e.req, "received byte", rx_data, e.data);
                    chk(rx_first == e.first, "R6", "first-byte flag", rx_first, e.first);
                end
            end
        end
    end

    // stray pull monitor for R10
    always @(negedge clk) if (rst_n && pull && !pull_allowed) stray++;

    task automatic bus_reset(input int low_us, input string req);
        int cw, cl, pdw, pdl;
        pdw = fast ? 3 : 30;
        pdl = fast ? 12 : 120;
        exp_q.push_back('{0, 8'h00, 1'b0, req});
        pull_allowed = 1'b1;
        m_low = 1'b1;
        wait_us(low_us);
        m_low = 1'b0;
        wait_clk(3);
        chk(reset_p == 1'b1, req, "reset pulse 3 cycles after release", reset_p, 1);
        chk(pull == 1'b0, "R4", "no pull in reset cycle", pull, 0);
        cw = 3;
        while (!pull && cw < 5000) begin @(negedge clk); cw++; end
        chk(cw >= (pdw - 1) * TICK_DIV && cw <= pdw * TICK_DIV + 6, "R4", "presence start clocks", cw, pdw * TICK_DIV);
        cl = 0;
        while (pull && cl < 5000) begin @(negedge clk); cl++; end
        chk(cl >= (pdl - 1) * TICK_DIV && cl <= pdl * TICK_DIV + 1, "R4", "presence length clocks", cl, pdl * TICK_DIV);
        pull_allowed = 1'b0;
        wait_us(fast ? 3 : 20);
    endtask

    task automatic write_bit(input bit b, input int low0);
        int low;
        low = b ? 1 : low0;
        m_low = 1'b1;
        wait_us(low);
        m_low = 1'b0;
        wait_us((b ? low0 - 1 : 0) + (fast ? 2 : 10));
    endtask

    task automatic write_byte(input logic [7:0] b, input bit first, input int low0, input string req);
        int s0;
        s0 = stray;
        exp_q.push_back('{1, b, first, req});
        for (int i = 0; i < 8; i++) write_bit(b[i], low0);
        chk(stray == s0, "R10", "stray pull cycles in write byte", stray - s0, 0);
    endtask

    task automatic read_bit(output bit b);
        m_low = 1'b1;
        wait_clk(TICK_DIV);
        m_low = 1'b0;
        if (fast) begin
            wait_clk(5);
            b = line;
            wait_clk(85);
        end else begin
            wait_us(14);
            b = line;
            wait_us(65);
        end
    endtask

    task automatic load_tx(input logic [7:0] b);
        tx_data = b;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    task automatic read_byte(input logic [7:0] b);
        logic [7:0] got;
        bit bit_v;
        load_tx(b);
        exp_q.push_back('{2, 8'h00, 1'b0, "R8"});
        pull_allowed = 1'b1;
        for (int i = 0; i < 8; i++) begin
            read_bit(bit_v);
            got[i] = bit_v;
        end
        pull_allowed = 1'b0;
        chk(got == b, "R7", "byte seen by master", got, b);
    endtask

    initial begin
        bit bv;
        wait_clk(5);
        chk(pull == 1'b0 && reset_p == 1'b0 && rx_valid == 1'b0 && tx_req == 1'b0,
            "R1", "outputs in reset", {pull, reset_p, rx_valid, tx_req}, 0);
        rst_n = 1'b1;
        wait_clk(20);

        // standard speed
        fast = 1'b0;
        bus_reset(480, "R2");
        write_byte(8'hA5, 1'b1, 70, "R5");
        write_byte(8'h3C, 1'b0, 70, "R6");
        read_byte(8'h96);
        write_byte(8'h01, 1'b0, 70, "R8");
        write_byte(8'h00, 1'b0, 118, "R2");
        bus_reset(130, "R2");

        // abort of a partial receive byte
        write_bit(1'b1, 70); write_bit(1'b0, 70); write_bit(1'b1, 70);
        bus_reset(480, "R9");
        write_byte(8'h5A, 1'b1, 70, "R9");

        // abort of a pending transmit byte
        load_tx(8'h00);
        pull_allowed = 1'b1;
        read_bit(bv);
        chk(bv == 1'b0, "R7", "tx zero bit pulls wire", bv, 0);
        read_bit(bv);
        pull_allowed = 1'b0;
        bus_reset(480, "R9");
        write_byte(8'hFF, 1'b1, 70, "R9");

        // overdrive speed
        fast = 1'b1;
        wait_us(5);
        bus_reset(48, "R3");
        write_byte(8'hC3, 1'b1, 8, "R5");
        read_byte(8'h69);
        write_byte(8'h00, 1'b0, 14, "R3");
        bus_reset(20, "R3");
        write_byte(8'h7E, 1'b1, 8, "R6");

        wait_us(5);
        chk(exp_q.size() == 0, "R5", "expected events left", exp_q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R1 watchdog expired: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule